// File: doc/BRIEF.md
# Dual-Channel Pointer-Addressed Register Front End

This block is the host-facing register file of a two-channel serial controller. Each channel has a control port and a data port on one shared access strobe. A host reaches most registers in two steps. First it writes a register number to the channel's control port, then its next control-port access on that channel reads or writes the selected register. The pointer then drops back to zero, so a bare control-port access lands on register 0. Register 8, the transmit and receive data register, can also be reached straight through the data port.

The register space has several special cases. Two registers are common to both channels. Register 7 is banked between a sync-character register and an alternate option register. Some written fields are one-shot commands that are not stored: channel and full resets, and clock-recovery commands. Some reads fold in live status from the channels or mirror stored settings. The serializers drive the status inputs and use the configuration outputs. Accesses must be spaced by a minimum number of clock cycles, and any access that comes too soon sets a sticky flag.

Top module: `sio_ptr_regfile`

## Requirements
- R1: After reset every configuration output is zero, `gap_viol_o` is 0, both pointers are 0, and all strobes are 0.
- R2: When a channel's pointer is 0, a control-port write loads the pointer from data bits 3:0. The next control-port access on that channel targets that register and then returns the pointer to 0. A control-port read with pointer 0 returns that channel's `st0_i`. Read data appears on `rd_data_o` the cycle after the access and holds until the next read.
- R3: A control-port write with pointer 0 and a nonzero bits 7:4 gives a one-cycle `cmd_stb_o` pulse for that channel, with `cmd_code_o` equal to bits 7:4.
- R4: Bit 0 of register 15 selects the target of register 7 writes. When it is 0, writes go to the sync register (`cfg_o[c][7]`). When it is 1, writes go to the alternate option register (`cfg_o[c][8]`).
- R5: Registers 2 and 9 are shared, so a write through either channel shows in `cfg_o[0]` and `cfg_o[1]` at the same index. Reading register 2 on channel A returns the stored value. On channel B it returns `{wr2[7:4], vstat_i, wr2[0]}`.
- R6: Bits 7:6 of a register 9 write are a reset command and are not stored, so register 9 keeps bits 5:0. The codes are: 01 clears channel A's registers and pointer, 10 does the same for channel B, and 11 clears both channels plus registers 2 and 9. `chan_rst_o` pulses for one cycle with the affected channels (bit 0 = A).
- R7: A register 14 write keeps only bits 4:0. A nonzero bits 7:5 gives a one-cycle `dpll_stb_o` pulse for that channel, with `dpll_code_o` equal to bits 7:5.
- R8: Register 3 read on channel A returns `{2'b00, ipend_i}`, where the bit order is 0 B ext/status, 1 B transmit, 2 B receive, 3 A ext/status, 4 A transmit, 5 A receive. On channel B it reads as 0.
- R9: When bit 6 of the alternate option register is set, registers 4, 5, 9 and 11 read back the stored registers 4, 5, 3 and 10. When that bit is clear, they read 0. Registers 12, 13 and 15 always read back their stored values. Registers 6, 7 and 14 read 0. Register 1 returns `st1_i` and register 10 returns `dpll_st_i`.
- R10: A write to register 8 gives a one-cycle `tx_push_o` pulse for that channel and loads `tx_data_o`. A read of register 8 returns `rx_data_i` and gives a one-cycle `rx_pop_o` pulse. Register 8 is reachable through the data port or the pointer, and data-port accesses leave the pointer unchanged.
- R11: An access that starts fewer than `MIN_GAP_CYC` cycles after the previous one, on any channel or port, sets `gap_viol_o`. The access still takes effect, and the flag clears only on `rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Access strobe, one cycle per access |
| acc_ch | input | 1 | Channel select, 0 = A, 1 = B |
| acc_dport | input | 1 | 1 = data port, 0 = control port |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_wdata | input | 8 | Write data |
| st0_i | input | 2x8 | Per-channel main status (register 0 read) |
| st1_i | input | 2x8 | Per-channel special status (register 1 read) |
| dpll_st_i | input | 2x8 | Per-channel clock-recovery status (register 10 read) |
| rx_data_i | input | 2x8 | Per-channel receive data (register 8 read) |
| ipend_i | input | 6 | Interrupt-pending bits |
| vstat_i | input | 3 | Status code folded into channel B register 2 read |
| rd_data_o | output | 8 | Registered read data |
| cfg_o | output | 2x16x8 | Stored configuration per channel, index 8 = alternate option |
| cmd_stb_o | output | 2 | Register 0 command strobe per channel |
| cmd_code_o | output | 4 | Register 0 command code |
| dpll_stb_o | output | 2 | Clock-recovery command strobe per channel |
| dpll_code_o | output | 3 | Clock-recovery command code |
| chan_rst_o | output | 2 | Channel reset pulse, bit 0 = A |
| tx_push_o | output | 2 | Transmit data write strobe per channel |
| tx_data_o | output | 8 | Transmit data |
| rx_pop_o | output | 2 | Receive data read strobe per channel |
| gap_viol_o | output | 1 | Sticky access-spacing violation |

## Verification
If a pointer were left nonzero, the very next control-port access would show it. A read would return a stored register instead of `st0_i`, or a write would land in `cfg_o` instead of reloading the pointer. That shows one cycle after the access. A wrong bank bit, alias enable or shared-register copy shows in `cfg_o` or `rd_data_o` one cycle after the write or read that uses it. If a one-shot field were stored, a later read-back would show it. A strobe that stuck high stays visible at the next sample. A gap counter that drifted would raise or miss `gap_viol_o` on the cycle after the offending access.

// File: rtl/sio_regif_pkg.sv
package sio_regif_pkg;

    localparam int DW        = 8;
    localparam int NREG      = 16;
    localparam int AW        = $clog2(NREG);
    localparam int NCH       = 2;
    localparam int BANK_BIT  = 0;   // register 15 bit choosing register 7 bank
    localparam int EXT_BIT   = 6;   // alternate option bit enabling mirrors

    localparam logic [AW-1:0] R_SHARED_VEC = AW'(2);
    localparam logic [AW-1:0] R_PEND       = AW'(3);
    localparam logic [AW-1:0] R_BANKED     = AW'(7);
    localparam logic [AW-1:0] R_DATA       = AW'(8);
    localparam logic [AW-1:0] R_MASTER     = AW'(9);
    localparam logic [AW-1:0] R_DPLL       = AW'(14);
    localparam logic [AW-1:0] R_ALTOPT     = AW'(8);   // storage slot of the alternate option

    typedef logic [NREG-1:0][DW-1:0] regbank_t;

    typedef struct packed {
        logic          en;
        logic          ch;
        logic          dport;
        logic          wr;
        logic [DW-1:0] d;
    } acc_t;

    typedef enum logic [1:0] {
        RST_NONE = 2'b00,
        RST_CHA  = 2'b01,
        RST_CHB  = 2'b10,
        RST_ALL  = 2'b11
    } rstcmd_e;

    function automatic logic [DW-1:0] rd_pick(
        input logic          chb,
        input logic [AW-1:0] t,
        input regbank_t      r,
        input logic [DW-1:0] s0,
        input logic [DW-1:0] s1,
        input logic [DW-1:0] ds,
        input logic [DW-1:0] rx,
        input logic [5:0]    ip,
        input logic [2:0]    vs
    );
        logic ext;
        ext = r[R_ALTOPT][EXT_BIT];
        case (t)
            4'd0:    rd_pick = s0;
            4'd1:    rd_pick = s1;
            4'd2:    rd_pick = chb ? {r[2][7:4], vs, r[2][0]} : r[2];
            4'd3:    rd_pick = chb ? '0 : {2'b00, ip};
            4'd4:    rd_pick = ext ? r[4]  : '0;
            4'd5:    rd_pick = ext ? r[5]  : '0;
            4'd8:    rd_pick = rx;
            4'd9:    rd_pick = ext ? r[3]  : '0;
            4'd10:   rd_pick = ds;
            4'd11:   rd_pick = ext ? r[10] : '0;
            4'd12:   rd_pick = r[12];
            4'd13:   rd_pick = r[13];
            4'd15:   rd_pick = r[15];
            default: rd_pick = '0;
        endcase
    endfunction

endpackage

// File: rtl/sio_gap_mon.sv
module sio_gap_mon #(
    parameter int MIN_GAP_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic acc,
    output logic viol
);
    localparam int CW = $clog2(MIN_GAP_CYC + 1);
    localparam logic [CW-1:0] CMAX = CW'(MIN_GAP_CYC);

    logic [CW-1:0] since;

    always_ff @(posedge clk) begin
        if (rst) begin
            since <= CMAX;
            viol  <= 1'b0;
        end else if (acc) begin
            since <= CW'(1);
            if (since < CMAX) viol <= 1'b1;
        end else if (since < CMAX) begin
            since <= since + CW'(1);
        end
    end

    assert_early_flag_R11: assert property (@(posedge clk) disable iff (rst)
        (acc && since < CMAX) |=> viol);
    assert_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        viol |=> viol);

endmodule

// File: rtl/sio_chan_regs.sv
module sio_chan_regs
    import sio_regif_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          chrst,
    input  logic          acc,
    input  logic          wr,
    input  logic [DW-1:0] wd,
    output logic [AW-1:0] ptr,
    output regbank_t      regs
);

    always_ff @(posedge clk) begin
        if (rst || chrst) begin
            ptr  <= '0;
            regs <= '0;
        end else if (acc) begin
            if (ptr == '0) begin
                if (wr) ptr <= wd[AW-1:0];
            end else begin
                ptr <= '0;
                if (wr) begin
                    case (ptr)
                        R_BANKED: begin
                            if (regs[15][BANK_BIT]) regs[R_ALTOPT] <= wd;
                            else                    regs[R_BANKED] <= wd;
                        end
                        R_DPLL:                        regs[R_DPLL] <= {3'b000, wd[4:0]};
                        R_SHARED_VEC, R_DATA, R_MASTER: ;
                        default:                       regs[ptr] <= wd;
                    endcase
                end
            end
        end
    end

    assert_ptr_return_R2: assert property (@(posedge clk) disable iff (rst)
        (acc && ptr != '0) |=> (ptr == '0));
    assert_dpll_keep_R7: assert property (@(posedge clk) disable iff (rst)
        (acc && wr && ptr == R_DPLL && !chrst) |=> (regs[R_DPLL] == {3'b000, $past(wd[4:0])}));
    assert_sync_bank_R4: assert property (@(posedge clk) disable iff (rst)
        (acc && wr && ptr == R_BANKED && !regs[15][BANK_BIT] && !chrst) |=> (regs[R_BANKED] == $past(wd)));

endmodule

// File: rtl/sio_ptr_regfile.sv
module sio_ptr_regfile
    import sio_regif_pkg::*;
#(
    parameter int MIN_GAP_CYC = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     acc_en,
    input  logic                     acc_ch,
    input  logic                     acc_dport,
    input  logic                     acc_wr,
    input  logic [7:0]               acc_wdata,
    input  logic [1:0][7:0]          st0_i,
    input  logic [1:0][7:0]          st1_i,
    input  logic [1:0][7:0]          dpll_st_i,
    input  logic [1:0][7:0]          rx_data_i,
    input  logic [5:0]               ipend_i,
    input  logic [2:0]               vstat_i,
    output logic [7:0]               rd_data_o,
    output logic [1:0][15:0][7:0]    cfg_o,
    output logic [1:0]               cmd_stb_o,
    output logic [3:0]               cmd_code_o,
    output logic [1:0]               dpll_stb_o,
    output logic [2:0]               dpll_code_o,
    output logic [1:0]               chan_rst_o,
    output logic [1:0]               tx_push_o,
    output logic [7:0]               tx_data_o,
    output logic [1:0]               rx_pop_o,
    output logic                     gap_viol_o
);

    acc_t                a;
    logic [NCH-1:0][AW-1:0] ptr;
    regbank_t [NCH-1:0]  loc;
    logic [DW-1:0]       wr2, wr9;
    logic [AW-1:0]       tgt;
    logic                reg_wr, reg_rd, cmd_wr;
    logic [NCH-1:0]      crst;
    rstcmd_e             rcmd;

    assign a      = '{en: acc_en, ch: acc_ch, dport: acc_dport, wr: acc_wr, d: acc_wdata};
    assign tgt    = a.dport ? R_DATA : ptr[a.ch];
    assign reg_wr = a.en &&  a.wr && (a.dport || ptr[a.ch] != '0);
    assign reg_rd = a.en && !a.wr;
    assign cmd_wr = a.en &&  a.wr && !a.dport && ptr[a.ch] == '0;
    assign rcmd   = rstcmd_e'(a.d[7:6]);

    always_comb begin
        crst = '0;
        if (reg_wr && tgt == R_MASTER) begin
            case (rcmd)
                RST_CHA: crst = 2'b01;
                RST_CHB: crst = 2'b10;
                RST_ALL: crst = 2'b11;
                default: crst = 2'b00;
            endcase
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        sio_chan_regs u_regs (
            .clk   (clk),
            .rst   (rst),
            .chrst (crst[g]),
            .acc   (a.en && !a.dport && a.ch == 1'(g)),
            .wr    (a.wr),
            .wd    (a.d),
            .ptr   (ptr[g]),
            .regs  (loc[g])
        );
    end

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            cfg_o[c]               = loc[c];
            cfg_o[c][R_SHARED_VEC] = wr2;
            cfg_o[c][R_MASTER]     = wr9;
        end
    end

    // shared registers
    always_ff @(posedge clk) begin
        if (rst || crst == 2'b11) begin
            wr2 <= '0;
            wr9 <= '0;
        end else if (reg_wr) begin
            if (tgt == R_SHARED_VEC) wr2 <= a.d;
            if (tgt == R_MASTER)     wr9 <= {2'b00, a.d[5:0]};
        end
    end

    // registered read data and one-shot strobes
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data_o   <= '0;
            cmd_stb_o   <= '0;
            cmd_code_o  <= '0;
            dpll_stb_o  <= '0;
            dpll_code_o <= '0;
            chan_rst_o  <= '0;
            tx_push_o   <= '0;
            tx_data_o   <= '0;
            rx_pop_o    <= '0;
        end else begin
            cmd_stb_o  <= '0;
            dpll_stb_o <= '0;
            tx_push_o  <= '0;
            rx_pop_o   <= '0;
            chan_rst_o <= crst;
            if (reg_rd) begin
                rd_data_o <= rd_pick(a.ch, tgt, cfg_o[a.ch], st0_i[a.ch], st1_i[a.ch],
                                     dpll_st_i[a.ch], rx_data_i[a.ch], ipend_i, vstat_i);
                if (tgt == R_DATA) rx_pop_o[a.ch] <= 1'b1;
            end
            if (cmd_wr && a.d[7:4] != 4'h0) begin
                cmd_stb_o[a.ch] <= 1'b1;
                cmd_code_o      <= a.d[7:4];
            end
            if (reg_wr && tgt == R_DPLL && a.d[7:5] != 3'b000) begin
                dpll_stb_o[a.ch] <= 1'b1;
                dpll_code_o      <= a.d[7:5];
            end
            if (reg_wr && tgt == R_DATA) begin
                tx_push_o[a.ch] <= 1'b1;
                tx_data_o       <= a.d;
            end
        end
    end

    sio_gap_mon #(.MIN_GAP_CYC(MIN_GAP_CYC)) u_gap (
        .clk  (clk),
        .rst  (rst),
        .acc  (a.en),
        .viol (gap_viol_o)
    );

    assert_pend_chb_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && a.ch && tgt == R_PEND) |=> (rd_data_o == 8'h00));
    assert_master_nostore_R6: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && tgt == R_MASTER) |=> (cfg_o[0][R_MASTER][7:6] == 2'b00));
    assert_push_single_R10: assert property (@(posedge clk) disable iff (rst)
        (a.en && a.dport && a.wr) |=> ($countones(tx_push_o) == 1));
    assert_shared_equal_R5: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && tgt == R_SHARED_VEC) |=> (cfg_o[0][2] == cfg_o[1][2]));

endmodule

// File: tb/sim_sio_ptr_regfile.sv
module sim_sio_ptr_regfile;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic acc_en = 0, acc_ch = 0, acc_dport = 0, acc_wr = 0;
    logic [7:0] acc_wdata = 0;
    logic [1:0][7:0] st0_i = '0, st1_i = '0, dpll_st_i = '0, rx_data_i = '0;
    logic [5:0] ipend_i = '0;
    logic [2:0] vstat_i = '0;
    logic [7:0] rd_data_o, tx_data_o;
    logic [1:0][15:0][7:0] cfg_o;
    logic [1:0] cmd_stb_o, dpll_stb_o, chan_rst_o, tx_push_o, rx_pop_o;
    logic [3:0] cmd_code_o;
    logic [2:0] dpll_code_o;
    logic gap_viol_o;

    sio_ptr_regfile u0 (.*);

    int checks = 0, errors = 0;
    bit done = 0;
    logic [7:0] s_rd, s_txd;
    logic [3:0] s_code;
    logic [2:0] s_dcode;
    logic [1:0] s_cmd, s_dstb, s_crst, s_push, s_pop;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic acc(input bit ch, input bit dp, input bit wr, input logic [7:0] d, input int gap);
        @(negedge clk);
        acc_en = 1; acc_ch = ch; acc_dport = dp; acc_wr = wr; acc_wdata = d;
        @(negedge clk);
        acc_en = 0;
        s_rd = rd_data_o; s_cmd = cmd_stb_o; s_code = cmd_code_o; s_dstb = dpll_stb_o;
        s_dcode = dpll_code_o; s_crst = chan_rst_o; s_push = tx_push_o; s_txd = tx_data_o;
        s_pop = rx_pop_o;
        repeat (gap - 1) @(negedge clk);
    endtask

    task automatic wreg(input bit ch, input logic [3:0] n, input logic [7:0] d);
        acc(ch, 0, 1, {4'h0, n}, 4);
        acc(ch, 0, 1, d, 4);
    endtask

    task automatic rreg(input bit ch, input logic [3:0] n);
        acc(ch, 0, 1, {4'h0, n}, 4);
        acc(ch, 0, 0, 8'h00, 4);
    endtask

    task automatic t_reset;
        chk("R1 cfg zero", {31'd0, cfg_o == '0}, 32'd1);
        chk("R1 viol", gap_viol_o, 0);
        chk("R1 strobes", {cmd_stb_o, dpll_stb_o, chan_rst_o, tx_push_o, rx_pop_o}, 0);
        acc(0, 0, 0, 8'h00, 4);
        chk("R2 RR0 chA", s_rd, 8'h5A);
    endtask

    task automatic t_pointer;
        wreg(0, 12, 8'h34);
        chk("R2 write A12", cfg_o[0][12], 8'h34);
        chk("R2 B12 untouched", cfg_o[1][12], 8'h00);
        acc(0, 0, 0, 8'h00, 4);
        chk("R2 pointer back to 0", s_rd, 8'h5A);
        rreg(0, 12);
        chk("R2 read A12", s_rd, 8'h34);
        chk("R2 rd holds", rd_data_o, 8'h34);
    endtask

    task automatic t_cmd;
        acc(1, 0, 1, 8'h30, 4);
        chk("R3 cmd strobe", s_cmd, 2'b10);
        chk("R3 cmd code", s_code, 4'h3);
        chk("R3 strobe clears", cmd_stb_o, 2'b00);
        acc(1, 0, 0, 8'h00, 4);
        chk("R3 ptr stays 0", s_rd, 8'hC3);
    endtask

    task automatic t_bank;
        wreg(0, 7, 8'h7E);
        chk("R4 sync reg", cfg_o[0][7], 8'h7E);
        wreg(0, 15, 8'h01);
        wreg(0, 7, 8'h81);
        chk("R4 alt option", cfg_o[0][8], 8'h81);
        chk("R4 sync kept", cfg_o[0][7], 8'h7E);
    endtask

    task automatic t_shared;
        wreg(1, 2, 8'hA5);
        chk("R5 wr2 on A", cfg_o[0][2], 8'hA5);
        rreg(0, 2);
        chk("R5 RR2 A", s_rd, 8'hA5);
        vstat_i = 3'b110;
        rreg(1, 2);
        chk("R5 RR2 B", s_rd, 8'hAD);
        wreg(0, 9, 8'h2B);
        chk("R5 wr9 on B", cfg_o[1][9], 8'h2B);
    endtask

    task automatic t_master_reset;
        wreg(1, 5, 8'h11);
        wreg(0, 5, 8'h22);
        wreg(0, 9, 8'h85);
        chk("R6 rst pulse B", s_crst, 2'b10);
        chk("R6 B cleared", cfg_o[1][5], 8'h00);
        chk("R6 A kept", cfg_o[0][5], 8'h22);
        chk("R6 wr9 low bits", cfg_o[0][9], 8'h05);
        chk("R6 pulse clears", chan_rst_o, 2'b00);
        wreg(0, 9, 8'hC3);
        chk("R6 rst pulse all", s_crst, 2'b11);
        chk("R6 all cleared", {31'd0, cfg_o == '0}, 32'd1);
    endtask

    task automatic t_dpll;
        wreg(1, 14, 8'hBF);
        chk("R7 kept bits", cfg_o[1][14], 8'h1F);
        chk("R7 strobe", s_dstb, 2'b10);
        chk("R7 code", s_dcode, 3'd5);
        wreg(1, 14, 8'h0C);
        chk("R7 no strobe", s_dstb, 2'b00);
        chk("R7 value", cfg_o[1][14], 8'h0C);
    endtask

    task automatic t_pending;
        ipend_i = 6'b101101;
        rreg(0, 3);
        chk("R8 RR3 A", s_rd, 8'h2D);
        rreg(1, 3);
        chk("R8 RR3 B", s_rd, 8'h00);
    endtask

    task automatic t_alias;
        wreg(0, 4, 8'h44); wreg(0, 5, 8'h55); wreg(0, 3, 8'h33);
        wreg(0, 10, 8'h1A); wreg(0, 13, 8'hD3);
        rreg(0, 4);  chk("R9 RR4 off", s_rd, 8'h00);
        rreg(0, 13); chk("R9 RR13", s_rd, 8'hD3);
        wreg(0, 15, 8'h01);
        wreg(0, 7, 8'h40);
        rreg(0, 4);  chk("R9 RR4", s_rd, 8'h44);
        rreg(0, 5);  chk("R9 RR5", s_rd, 8'h55);
        rreg(0, 9);  chk("R9 RR9", s_rd, 8'h33);
        rreg(0, 11); chk("R9 RR11", s_rd, 8'h1A);
        rreg(0, 15); chk("R9 RR15", s_rd, 8'h01);
        rreg(0, 14); chk("R9 RR14", s_rd, 8'h00);
        rreg(0, 1);  chk("R9 RR1", s_rd, 8'h9E);
        rreg(0, 10); chk("R9 RR10", s_rd, 8'h6B);
    endtask

    task automatic t_data;
        acc(0, 1, 1, 8'h99, 4);
        chk("R10 push A", s_push, 2'b01);
        chk("R10 tx data", s_txd, 8'h99);
        acc(0, 0, 1, 8'h0C, 4);
        acc(1, 1, 0, 8'h00, 4);
        chk("R10 rx data B", s_rd, 8'h6C);
        chk("R10 pop B", s_pop, 2'b10);
        acc(0, 0, 1, 8'h77, 4);
        chk("R10 ptr untouched", cfg_o[0][12], 8'h77);
        wreg(1, 8, 8'h42);
        chk("R10 push via ptr", s_push, 2'b10);
        chk("R10 tx via ptr", s_txd, 8'h42);
    endtask

    task automatic t_gap;
        chk("R11 no viol when spaced", gap_viol_o, 0);
        acc(0, 0, 1, 8'h0D, 1);
        acc(0, 0, 1, 8'h5C, 4);
        chk("R11 viol set", gap_viol_o, 1);
        chk("R11 access done", cfg_o[0][13], 8'h5C);
        repeat (10) @(negedge clk);
        chk("R11 viol sticky", gap_viol_o, 1);
    endtask

    task automatic summary;
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        st0_i[0] = 8'h5A; st0_i[1] = 8'hC3;
        st1_i[0] = 8'h9E; dpll_st_i[0] = 8'h6B;
        rx_data_i[1] = 8'h6C;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset;
        t_pointer;
        t_cmd;
        t_bank;
        t_shared;
        t_master_reset;
        t_dpll;
        t_pending;
        t_alias;
        t_data;
        t_gap;
        summary;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        summary;
    end

endmodule